// File: doc/BRIEF.md
# DMA Interrupt Status and Register Block

This block is the register front end and interrupt collector of a multi-channel DMA controller built for either two or eight channels. The channel engines report finished transfers and faults with one-cycle set pulses. The block keeps these as raw per-channel flags and masks them with enable bits taken from each channel's own configuration word. It drives one interrupt line that is high while any masked flag is set. Software reads the raw and masked views of both flag kinds and clears flags by writing ones.

The same block decodes a simple 32-bit register bus. The bus reaches a set of global registers, a window of five words for each channel, and eight read-only identification words. The stored channel words go back out to the engines as flat vectors. The controller enable bit goes out as well.

A small access state machine handles each bus request. It has three states. `ST_IDLE` waits for `bus_sel`. The transition *accept-read* goes to `ST_RD_RESP` and the transition *accept-write* goes to `ST_WR_RESP`. Both response states spend one cycle with `bus_ack` high and then take the transition *done* back to `ST_IDLE`. A request seen outside `ST_IDLE` is not accepted.

Top module: `dma_regblk`

## Requirements
- R1: After reset every stored register and flag is zero, `irq` is low, and `ctl_en` is low.
- R2: Word offset 0x00 reads the combined masked status, `(tc_raw & tc_mask) | (err_raw & err_mask)`. Offset 0x04 reads the masked terminal-count flags and 0x0C reads the masked error flags. Offset 0x14 reads the raw terminal-count flags and 0x18 reads the raw error flags. Channel c sits in bit c of each of these registers.
- R3: Bit 15 of channel c's configuration word is its terminal-count mask bit. Bit 14 is its error mask bit.
- R4: A write to 0x08 clears each raw terminal-count flag whose bit is 1 in the written data. A write to 0x10 does the same for the error flags. All other flags keep their values. A flag is set by the clock edge that samples its pulse on `tc_set` or `err_set`.
- R5: When a set pulse and a clear write meet on the same flag in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when the combined status is nonzero. It follows the flags in the same cycle, with no extra register stage.
- R7: Channel c's window starts at 0x100 + 0x20*c. Its words 0 to 4 hold the source address, the destination address, the link pointer, the control word and the configuration word. These words read back as written and appear on `ch_src`, `ch_dst`, `ch_link`, `ch_ctrl` and `ch_cfg`, in slice c. Words 5 to 7 of a window read as zero.
- R8: Offset 0x1C reads one bit per channel. Bit c is bit 0 of channel c's configuration word.
- R9: Offsets 0xFE0 to 0xFFC read one identification byte per word, in this order: 0x80, then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. The first byte is 0x81 instead when NUM_CH is 2.
- R10: Offset 0x30 is the global configuration register and offset 0x34 is the sync register. Both read back as written. Bit 0 of 0x30 drives `ctl_en`. Offsets 0x20 to 0x2C read as zero.
- R11: An access to a window whose index is NUM_CH or above does not change any register and reads as zero. `bus_err` is high in its response cycle, and only then.
- R12: A request is accepted in `ST_IDLE`. `bus_ack`, `bus_rdata` and `bus_err` are valid in the next cycle. A register written by the accepted request holds its new value from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Response cycle marker |
| bus_err | output | 1 | Access to a window that does not exist |
| tc_set | input | NUM_CH | Terminal-count set pulses, one per channel |
| err_set | input | NUM_CH | Error set pulses, one per channel |
| ch_src | output | 32*NUM_CH | Source address words, one slice per channel |
| ch_dst | output | 32*NUM_CH | Destination address words |
| ch_link | output | 32*NUM_CH | Link pointer words |
| ch_ctrl | output | 32*NUM_CH | Control words |
| ch_cfg | output | 32*NUM_CH | Configuration words |
| ctl_en | output | 1 | Controller enable |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted raw flag changes `irq` at the port in the same cycle and changes the raw status read in the very next access. A wrong mask bit shows only in the masked reads, which is why every mask pattern is swept against every flag pattern. A window decode that wraps an out-of-range index onto a real channel leaves `bus_err` correct. It shows up only when the real channel is read back, so those words are checked right after each out-of-range write. A slip in the access state machine moves `bus_ack` and the read data by one cycle, and the first read after reset exposes it.

// File: rtl/dma_regblk_pkg.sv
package dma_regblk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_RESP = 2'd2
    } bus_state_t;

    localparam logic [9:0] W_STAT    = 10'd0;
    localparam logic [9:0] W_TC_STAT = 10'd1;
    localparam logic [9:0] W_TC_CLR  = 10'd2;
    localparam logic [9:0] W_ER_STAT = 10'd3;
    localparam logic [9:0] W_ER_CLR  = 10'd4;
    localparam logic [9:0] W_TC_RAW  = 10'd5;
    localparam logic [9:0] W_ER_RAW  = 10'd6;
    localparam logic [9:0] W_ENABLED = 10'd7;
    localparam logic [9:0] W_GCFG    = 10'd12;
    localparam logic [9:0] W_SYNC    = 10'd13;

    localparam int TC_MASK_BIT = 15;
    localparam int ER_MASK_BIT = 14;

    function automatic logic [7:0] id_byte(input logic [2:0] k, input int nch);
        logic [7:0] b;
        case (k)
            3'd0: b = (nch == 2) ? 8'h81 : 8'h80;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_regblk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr,
    output logic acc_rd,
    output logic acc_wr,
    output logic ack
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        acc_rd  = 1'b0;
        acc_wr  = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel && wr) begin
                    acc_wr  = 1'b1;
                    state_d = ST_WR_RESP;
                end else if (sel) begin
                    acc_rd  = 1'b1;
                    state_d = ST_RD_RESP;
                end
            end
            ST_RD_RESP: begin
                ack     = 1'b1;
                state_d = ST_IDLE;
            end
            ST_WR_RESP: begin
                ack     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] raw_o
);
    for (genvar b = 0; b < N; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     raw_o[b] <= 1'b0;
            else if (set_i[b])              raw_o[b] <= 1'b1;
            else if (clr_en && clr_bits[b]) raw_o[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank #(
    parameter int NUM_CH = 8,
    parameter int DW     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_idx,
    input  logic [2:0]         wr_word,
    input  logic [DW-1:0]      wr_data,
    output logic [NUM_CH*DW-1:0] src_o,
    output logic [NUM_CH*DW-1:0] dst_o,
    output logic [NUM_CH*DW-1:0] link_o,
    output logic [NUM_CH*DW-1:0] ctrl_o,
    output logic [NUM_CH*DW-1:0] cfg_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_idx == 3'(c));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_o[c*DW +: DW]  <= '0;
                dst_o[c*DW +: DW]  <= '0;
                link_o[c*DW +: DW] <= '0;
                ctrl_o[c*DW +: DW] <= '0;
                cfg_o[c*DW +: DW]  <= '0;
            end else if (hit) begin
                case (wr_word)
                    3'd0: src_o[c*DW +: DW]  <= wr_data;
                    3'd1: dst_o[c*DW +: DW]  <= wr_data;
                    3'd2: link_o[c*DW +: DW] <= wr_data;
                    3'd3: ctrl_o[c*DW +: DW] <= wr_data;
                    3'd4: cfg_o[c*DW +: DW]  <= wr_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_regblk.sv
module dma_regblk
    import dma_regblk_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    input  logic [NUM_CH-1:0]    tc_set,
    input  logic [NUM_CH-1:0]    err_set,
    output logic [NUM_CH*32-1:0] ch_src,
    output logic [NUM_CH*32-1:0] ch_dst,
    output logic [NUM_CH*32-1:0] ch_link,
    output logic [NUM_CH*32-1:0] ch_ctrl,
    output logic [NUM_CH*32-1:0] ch_cfg,
    output logic                 ctl_en,
    output logic                 irq
);
    localparam int DW   = 32;
    localparam int PADW = DW - NUM_CH;

    logic              acc_rd, acc_wr;
    logic [9:0]        word_a;
    logic              win_hit, win_bad, id_hit;
    logic [2:0]        win_idx, win_word;
    logic [NUM_CH-1:0] tc_raw, err_raw, tc_mask, err_mask, en_map;
    logic [NUM_CH-1:0] tc_act, err_act;
    logic [DW-1:0]     gcfg_q, sync_q, rd_val;
    logic [DW-1:0]     rdata_q;
    logic              err_q;

    dma_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .acc_rd (acc_rd),
        .acc_wr (acc_wr),
        .ack    (bus_ack)
    );

    assign word_a   = bus_addr[11:2];
    assign win_hit  = (bus_addr[11:8] == 4'h1);
    assign win_idx  = bus_addr[7:5];
    assign win_word = bus_addr[4:2];
    assign win_bad  = win_hit && (int'(win_idx) >= NUM_CH);
    assign id_hit   = (bus_addr[11:5] == 7'h7F);

    dma_chan_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr && win_hit && !win_bad),
        .wr_idx  (win_idx),
        .wr_word (win_word),
        .wr_data (bus_wdata),
        .src_o   (ch_src),
        .dst_o   (ch_dst),
        .link_o  (ch_link),
        .ctrl_o  (ch_ctrl),
        .cfg_o   (ch_cfg)
    );

    dma_irq_flags #(.N(NUM_CH)) u_tc_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tc_set),
        .clr_en   (acc_wr && !win_hit && word_a == W_TC_CLR),
        .clr_bits (bus_wdata[NUM_CH-1:0]),
        .raw_o    (tc_raw)
    );

    dma_irq_flags #(.N(NUM_CH)) u_err_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_set),
        .clr_en   (acc_wr && !win_hit && word_a == W_ER_CLR),
        .clr_bits (bus_wdata[NUM_CH-1:0]),
        .raw_o    (err_raw)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign tc_mask[c]  = ch_cfg[c*DW + TC_MASK_BIT];
        assign err_mask[c] = ch_cfg[c*DW + ER_MASK_BIT];
        assign en_map[c]   = ch_cfg[c*DW];
    end

    assign tc_act  = tc_raw & tc_mask;
    assign err_act = err_raw & err_mask;
    assign irq     = |(tc_act | err_act);
    assign ctl_en  = gcfg_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcfg_q <= '0;
            sync_q <= '0;
        end else if (acc_wr && !win_hit) begin
            if (word_a == W_GCFG) gcfg_q <= bus_wdata;
            if (word_a == W_SYNC) sync_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        if (id_hit) begin
            rd_val = {24'h0, id_byte(bus_addr[4:2], NUM_CH)};
        end else if (win_hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (win_idx == 3'(c)) begin
                    case (win_word)
                        3'd0: rd_val = ch_src[c*DW +: DW];
                        3'd1: rd_val = ch_dst[c*DW +: DW];
                        3'd2: rd_val = ch_link[c*DW +: DW];
                        3'd3: rd_val = ch_ctrl[c*DW +: DW];
                        3'd4: rd_val = ch_cfg[c*DW +: DW];
                        default: rd_val = '0;
                    endcase
                end
            end
        end else begin
            case (word_a)
                W_STAT:    rd_val = {{PADW{1'b0}}, tc_act | err_act};
                W_TC_STAT: rd_val = {{PADW{1'b0}}, tc_act};
                W_ER_STAT: rd_val = {{PADW{1'b0}}, err_act};
                W_TC_RAW:  rd_val = {{PADW{1'b0}}, tc_raw};
                W_ER_RAW:  rd_val = {{PADW{1'b0}}, err_raw};
                W_ENABLED: rd_val = {{PADW{1'b0}}, en_map};
                W_GCFG:    rd_val = gcfg_q;
                W_SYNC:    rd_val = sync_q;
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (acc_rd || acc_wr) && win_bad;
            if (acc_rd) rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
endmodule

// File: rtl/dma_regblk_chk.sv
module dma_regblk_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [NUM_CH-1:0] tc_set,
    input logic [NUM_CH-1:0] err_set,
    input logic [NUM_CH-1:0] tc_raw,
    input logic [NUM_CH-1:0] err_raw,
    input logic              ctl_en
);
    // R5: a set pulse always leaves its flag set, whatever else happens
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        |tc_set |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    // R4: no raw flag rises without its pulse
    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_raw & ~$past(err_raw) & ~$past(err_set)) == '0));

    // R11: the error response lasts a single cycle
    assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    // R12: a request seen while idle is answered in the next cycle
    assert_ack_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ack) |=> bus_ack);

    // R12: the response cycle never repeats
    assert_ack_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R10: the enable output changes only after a write
    assert_en_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(ctl_en));
endmodule

bind dma_regblk dma_regblk_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_ack (bus_ack),
    .bus_err (bus_err),
    .tc_set  (tc_set),
    .err_set (err_set),
    .tc_raw  (tc_raw),
    .err_raw (err_raw),
    .ctl_en  (ctl_en)
);

// File: tb/dma_regblk_tb.sv
`timescale 1ns/1ps
module dma_regblk_tb;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ack, bus_err;
    logic [NCH-1:0] tc_set = '0, err_set = '0;
    logic [NCH*32-1:0] ch_src, ch_dst, ch_link, ch_ctrl, ch_cfg;
    logic ctl_en, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_regblk #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .tc_set(tc_set), .err_set(err_set),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link), .ch_ctrl(ch_ctrl),
        .ch_cfg(ch_cfg), .ctl_en(ctl_en), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic last_err, last_ack;

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tc_set = ts; err_set = es;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; tc_set = '0; err_set = '0;
        last_err = bus_err; last_ack = bus_ack;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_write(a, d, '0, '0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata; last_err = bus_err; last_ack = bus_ack;
    endtask

    task automatic pulse(input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
        @(negedge clk);
        tc_set = ts; err_set = es;
        @(negedge clk);
        tc_set = '0; err_set = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] idb [8];
        idb[0] = 8'h81; idb[1] = 8'h10; idb[2] = 8'h04; idb[3] = 8'h0A;
        idb[4] = 8'h0D; idb[5] = 8'hF0; idb[6] = 8'h05; idb[7] = 8'hB1;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 ctl_en", ctl_en, 0);
        check("R1 cfg", ch_cfg, 0);
        rst_n = 1;
        rd(12'h014, v); check("R1 tc raw", v, 0);
        check("R12 ack in response cycle", last_ack, 1);
        rd(12'h030, v); check("R1 gcfg", v, 0);

        // R9: identification bytes
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(k*4), v);
            check("R9 id byte", v, {24'h0, idb[k]});
        end

        // R7: channel windows, and words 5..7 read zero
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++)
                wr(12'h100 + 12'(c*32 + w*4), 32'hA500_0000 | (c << 8) | (w << 4) | 32'h3);
        for (int c = 0; c < NCH; c++) begin
            for (int w = 0; w < 8; w++) begin
                rd(12'h100 + 12'(c*32 + w*4), v);
                check("R7 window read", v, (w < 5) ? (32'hA500_0000 | (c << 8) | (w << 4) | 32'h3) : 32'h0);
                check("R11 no err in range", last_err, 0);
            end
            check("R7 ch_src", ch_src[c*32 +: 32], 32'hA500_0003 | (c << 8));
            check("R7 ch_dst", ch_dst[c*32 +: 32], 32'hA500_0013 | (c << 8));
            check("R7 ch_link", ch_link[c*32 +: 32], 32'hA500_0023 | (c << 8));
            check("R7 ch_ctrl", ch_ctrl[c*32 +: 32], 32'hA500_0033 | (c << 8));
            check("R7 ch_cfg", ch_cfg[c*32 +: 32], 32'hA500_0043 | (c << 8));
        end

        // R11: out-of-range windows
        for (int c = NCH; c < 8; c++) begin
            for (int w = 0; w < 5; w++) begin
                wr(12'h100 + 12'(c*32 + w*4), 32'hDEAD_BEEF);
                check("R11 write err", last_err, 1);
                rd(12'h100 + 12'(c*32 + w*4), v);
                check("R11 read zero", v, 0);
                check("R11 read err", last_err, 1);
                rd(12'h100 + 12'((c % NCH)*32 + w*4), v);
                check("R11 no alias", v, 32'hA500_0000 | ((c % NCH) << 8) | (w << 4) | 32'h3);
            end
        end

        // R8: enabled bitmap
        wr(12'h110, 32'h1); wr(12'h130, 32'h0);
        rd(12'h01C, v); check("R8 bitmap 01", v, 1);
        wr(12'h130, 32'h1);
        rd(12'h01C, v); check("R8 bitmap 11", v, 3);
        wr(12'h110, 32'h0);
        rd(12'h01C, v); check("R8 bitmap 10", v, 2);

        // R10: global config, sync, soft request words
        wr(12'h030, 32'h0000_0005);
        check("R10 ctl_en on", ctl_en, 1);
        rd(12'h030, v); check("R10 gcfg read", v, 32'h5);
        wr(12'h030, 32'h0);
        check("R10 ctl_en off", ctl_en, 0);
        wr(12'h034, 32'h1234_5678);
        rd(12'h034, v); check("R10 sync read", v, 32'h1234_5678);
        for (int k = 0; k < 4; k++) begin
            rd(12'h020 + 12'(k*4), v); check("R10 soft zero", v, 0);
        end

        // R2 R3 R6: sweep masks against flag patterns
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 16; p++) begin
                logic [1:0] tm, em, tp, ep, ta, ea;
                tm = 2'(m); em = 2'(m >> 2); tp = 2'(p); ep = 2'(p >> 2);
                ta = tm & tp; ea = em & ep;
                for (int c = 0; c < NCH; c++)
                    wr(12'h110 + 12'(c*32), (32'(tm[c]) << 15) | (32'(em[c]) << 14));
                wr(12'h008, 32'hFF); wr(12'h010, 32'hFF);
                check("R4 cleared irq", irq, 0);
                pulse(tp, ep);
                check("R6 irq", irq, (ta | ea) != 0);
                rd(12'h000, v); check("R2 combined", v, 32'(ta | ea));
                rd(12'h004, v); check("R3 tc masked", v, 32'(ta));
                rd(12'h00C, v); check("R3 err masked", v, 32'(ea));
                rd(12'h014, v); check("R2 tc raw", v, 32'(tp));
                rd(12'h018, v); check("R2 err raw", v, 32'(ep));
            end
        end

        // R4: partial write-one-to-clear
        pulse(2'b11, 2'b11);
        wr(12'h008, 32'h2);
        rd(12'h014, v); check("R4 tc partial", v, 1);
        rd(12'h018, v); check("R4 err untouched", v, 3);
        wr(12'h010, 32'h1);
        rd(12'h018, v); check("R4 err partial", v, 2);

        // R5: set beats clear in the same cycle
        bus_write(12'h008, 32'h3, 2'b01, 2'b00);
        rd(12'h014, v); check("R5 tc set wins", v, 1);
        bus_write(12'h010, 32'h3, 2'b00, 2'b10);
        rd(12'h018, v); check("R5 err set wins", v, 2);

        done = 1;
        finish_run();
    end
endmodule